// File: doc/BRIEF.md
# Idle-Gap Receive Frame Delimiter

This block sits beside a byte-oriented serial receiver and splits the received byte stream into messages by timing silence on the raw receive line. The first byte that arrives while the block is idle opens a frame and is written to buffer address 0. Every later byte goes to the next address without any outside involvement. An idle counter runs from the moment the frame opens and restarts on every transition of the receive line. When the counter reaches the programmed gap length with the line still quiet, the frame is closed.

On closing, the block gives a one-cycle done pulse together with the number of bytes stored and an overflow flag. It then waits for the next first byte. The gap length should be set longer than the largest pause between bytes inside one message and shorter than the silence between messages. Baud timing and deserialisation are done outside the block.

Top module: `idle_gap_framer`

## Requirements
- R1: After a synchronous active-low reset, frame_done, frame_ovf and frame_len are 0, and wr_en is 0 while byte_valid is low.
- R2: While the block is idle, a byte_valid opens a frame. In that same cycle, wr_en is 1, wr_addr is 0 and wr_data equals byte_data.
- R3: Inside an open frame, each accepted byte is written in the cycle its byte_valid is high, at addresses 1, 2, 3 and so on in arrival order, with wr_data equal to byte_data.
- R4: If the receive line does not change, frame_done is first high gap_len+1 clock edges after the edge that samples the opening byte. It stays high for exactly one cycle.
- R5: Both rising and falling changes of rx_line restart the idle count. frame_done then rises gap_len+3 edges after the first clock edge that samples the changed line level. This allows for two synchroniser stages and one edge-detect stage.
- R6: gap_len is captured when a frame opens, so later changes to it do not affect that frame. A captured value of 0 acts as 1.
- R7: The buffer holds 2^ADDR_W bytes. Bytes beyond that are not written (wr_en stays 0), and the frame closes with frame_len = 2^ADDR_W and frame_ovf = 1.
- R8: frame_len reports the number of bytes written in the frame. frame_len and frame_ovf keep their values until the next frame closes.
- R9: A byte_valid in the cycle in which the timeout falls due is dropped. It is not written, it does not add to frame_len, and it does not open a new frame.
- R10: Changes on rx_line while the block is idle do not open a frame and cause no frame_done.
- R11: Once a frame has closed, the block is idle, and the next byte opens a new frame at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Raw asynchronous receive line |
| byte_valid | input | 1 | One-cycle strobe: byte_data holds a received byte |
| byte_data | input | DATA_W | Received byte |
| gap_len | input | GAP_W | Idle gap in clock cycles that ends a frame |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | DATA_W | Buffer write data |
| frame_len | output | ADDR_W+1 | Number of bytes in the last closed frame |
| frame_done | output | 1 | One-cycle pulse when a frame closes |
| frame_ovf | output | 1 | Last closed frame lost bytes to a full buffer |

## Verification
The bench builds the block with ADDR_W = 3, which gives an 8-entry buffer. Frames of up to eleven bytes therefore drive the buffer past full, so the drop-and-flag path and the exact full count can be checked. GAP_W keeps its default of 16. The bench uses gap values from 0 to 10, so every timeout latency, including the zero-means-one case, can be counted edge by edge within a few dozen cycles. Single changes of each polarity on the line, placed at known cycles, show where the idle count restarts.

// File: rtl/igf_pkg.sv
// Shared types for the idle-gap frame delimiter.
package igf_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } igf_state_e;
endpackage

// File: rtl/rx_edge_sync.sv
// Synchronises the asynchronous receive line with two flops and then
// flags any change of the synchronised level, rising or falling.
// Assumes: the line idles high, so the flops reset to 1.
module rx_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_edge
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchroniser followed by a one-cycle history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // A change in either direction counts as an edge.
    assign line_edge = sync_q ^ prev_q;
endmodule

// File: rtl/idle_gap_timer.sv
// Counts clock cycles of line silence in an open frame and raises hit
// when the count reaches the gap captured when the frame opened.
// Assumes: load and run are never both high; a zero gap is taken as 1.
module idle_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic             restart,
    input  logic [GAP_W-1:0] gap_in,
    output logic             hit
);
    localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(1);

    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] gap_q;

    // Capture the gap on load; count up, saturating, or restart on an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            gap_q <= GAP_MIN;
        end else if (load) begin
            cnt_q <= '0;
            gap_q <= (gap_in == '0) ? GAP_MIN : gap_in;
        end else if (run) begin
            if (restart)
                cnt_q <= '0;
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + GAP_W'(1);
        end
    end

    // Timeout: silent for the full gap, with no edge in this cycle.
    assign hit = run && !restart && (cnt_q >= gap_q);
endmodule

// File: rtl/frame_ctrl.sv
// Frame state machine: opens a frame on the first byte, steers bytes
// to consecutive buffer addresses, drops bytes once the buffer is full,
// and publishes the length and overflow state on timeout.
// Assumes: byte_valid is a one-cycle strobe per byte.
module frame_ctrl
    import igf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              gap_hit,
    output logic              open_frame,
    output logic              armed,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W:0]   frame_len,
    output logic              frame_done,
    output logic              frame_ovf
);
    localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;

    igf_state_e      state_q;
    logic [ADDR_W:0] count_q;
    logic            ovf_q;
    logic            room;
    logic            take;

    assign armed      = (state_q == ST_ACTIVE);
    assign open_frame = !armed && byte_valid;
    assign room       = (count_q < DEPTH);
    assign take       = armed && byte_valid && !gap_hit;

    // Buffer write path, driven in the same cycle as the byte strobe.
    always_comb begin
        wr_en   = open_frame || (take && room);
        wr_addr = armed ? count_q[ADDR_W-1:0] : '0;
        wr_data = byte_data;
    end

    // Frame state, byte count and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (open_frame) begin
            state_q <= ST_ACTIVE;
            count_q <= (ADDR_W+1)'(1);
            ovf_q   <= 1'b0;
        end else if (gap_hit) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else if (take) begin
            if (room)
                count_q <= count_q + (ADDR_W+1)'(1);
            else
                ovf_q <= 1'b1;
        end
    end

    // Result registers: pulse done, hold length and overflow until the next close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_len  <= '0;
            frame_ovf  <= 1'b0;
        end else begin
            frame_done <= gap_hit;
            if (gap_hit) begin
                frame_len <= count_q;
                frame_ovf <= ovf_q;
            end
        end
    end
endmodule

// File: rtl/idle_gap_framer.sv
// Top level of the idle-gap frame delimiter: edge detection on the raw
// line, the idle gap timer and the frame controller.
// Assumes: byte_valid comes from a receiver clocked by clk.
module idle_gap_framer #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic [GAP_W-1:0]  gap_len,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W:0]   frame_len,
    output logic              frame_done,
    output logic              frame_ovf
);
    logic line_edge;
    logic gap_hit;
    logic open_frame;
    logic armed;

    rx_edge_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (rx_line),
        .line_edge (line_edge)
    );

    idle_gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (open_frame),
        .run     (armed),
        .restart (line_edge),
        .gap_in  (gap_len),
        .hit     (gap_hit)
    );

    frame_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .gap_hit    (gap_hit),
        .open_frame (open_frame),
        .armed      (armed),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_len  (frame_len),
        .frame_done (frame_done),
        .frame_ovf  (frame_ovf)
    );
endmodule

// File: rtl/idle_gap_framer_chk.sv
// Checker for the idle-gap frame delimiter, bound into the top module.
module idle_gap_framer_chk #(
    parameter int ADDR_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_done,
    input logic [ADDR_W:0] frame_len,
    input logic            frame_ovf,
    input logic            armed,
    input logic            gap_hit,
    input logic            line_edge
);
    localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;

    // Done lasts a single cycle.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // A timeout is followed by done on the next cycle.
    assert_hit_to_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gap_hit |=> frame_done);

    // An edge on the line restarts the count, so no timeout follows next cycle.
    assert_edge_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_edge |=> !gap_hit);

    // Overflow is only reported together with a full buffer count.
    assert_ovf_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ovf |-> (frame_len == DEPTH));

    // After done the block is idle.
    assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !armed);
endmodule

bind idle_gap_framer idle_gap_framer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .frame_ovf  (frame_ovf),
    .armed      (armed),
    .gap_hit    (gap_hit),
    .line_edge  (line_edge)
);

// File: tb/idle_gap_framer_tb.sv
`timescale 1ns/1ps
module idle_gap_framer_tb;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int GAP_W  = 16;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NVEC   = 5;

    // {bytes, toggle cycles before each later byte, gap, expected len, expected ovf}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'd1,  8'd2, 16'd6, 8'd1, 8'd0},
        {8'd3,  8'd2, 16'd6, 8'd3, 8'd0},
        {8'd8,  8'd3, 16'd8, 8'd8, 8'd0},
        {8'd11, 8'd2, 16'd6, 8'd8, 8'd1},
        {8'd5,  8'd1, 16'd4, 8'd5, 8'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_line = 1'b1;
    logic              byte_valid = 1'b0;
    logic [DATA_W-1:0] byte_data = '0;
    logic [GAP_W-1:0]  gap_len = '0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W:0]   frame_len;
    logic              frame_done;
    logic              frame_ovf;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int arm_cyc;
    int lat;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    idle_gap_framer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .gap_len    (gap_len),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_len  (frame_len),
        .frame_done (frame_done),
        .frame_ovf  (frame_ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Drive one byte strobe, check the write port, then clock it in.
    task automatic put_byte(input logic [7:0] d, input bit exp_en,
                            input int exp_addr, input string req);
        byte_valid = 1'b1;
        byte_data  = d;
        #1;
        chk(wr_en == exp_en, req, "wr_en", int'(wr_en), int'(exp_en));
        if (exp_en)
            chk(wr_addr == exp_addr && wr_data == d, req, "wr_addr",
                int'(wr_addr), exp_addr);
        step();
        byte_valid = 1'b0;
    endtask

    // Wait for done; latency counted from the edge that sampled the opening byte.
    task automatic wait_done(output int l);
        l = -1;
        for (int i = 0; i < 300; i++) begin
            if (frame_done) begin
                l = cyc - arm_cyc;
                break;
            end
            step();
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) step();
        // R1: reset state
        chk(frame_done == 0 && frame_ovf == 0 && frame_len == 0 && wr_en == 0,
            "R1", "reset outputs", int'(frame_len), 0);
        rst_n = 1'b1;
        step();

        // Table-driven frames: R2, R3, R7, R8, R11
        for (int v = 0; v < NVEC; v++) begin
            int nb  = int'(VEC[v][47:40]);
            int sp  = int'(VEC[v][39:32]);
            int elen = int'(VEC[v][15:8]);
            int eovf = int'(VEC[v][7:0]);
            gap_len = VEC[v][31:16];
            for (int b = 0; b < nb; b++) begin
                if (b > 0)
                    for (int t = 0; t < sp; t++) begin
                        rx_line = ~rx_line;
                        step();
                    end
                put_byte(8'hA0 + 8'(b), b < DEPTH, b, b == 0 ? "R2" : (b < DEPTH ? "R3" : "R7"));
                if (b == 0) arm_cyc = cyc;
            end
            wait_done(lat);
            chk(lat > 0, "R11", "frame closed", lat, 1);
            chk(frame_len == elen, "R8", "frame_len", int'(frame_len), elen);
            chk(frame_ovf == eovf, "R7", "frame_ovf", int'(frame_ovf), eovf);
            repeat (5) step();
            chk(frame_len == elen && frame_ovf == eovf, "R8", "held len", int'(frame_len), elen);
        end

        // R4: exact latency with a quiet line, and one-cycle pulse
        gap_len = 16'd10;
        put_byte(8'h11, 1, 0, "R2");
        arm_cyc = cyc;
        wait_done(lat);
        chk(lat == 11, "R4", "latency quiet", lat, 11);
        step();
        chk(frame_done == 0, "R4", "pulse width", int'(frame_done), 0);
        repeat (4) step();

        // R5: a rising then a falling change restart the count
        rx_line = 1'b0;
        repeat (5) step();
        put_byte(8'h22, 1, 0, "R5");
        arm_cyc = cyc;
        repeat (3) step();
        rx_line = 1'b1;       // first sampled at arm+4
        repeat (5) step();
        rx_line = 1'b0;       // first sampled at arm+9
        wait_done(lat);
        chk(lat == 22, "R5", "latency after two changes", lat, 22);
        chk(frame_len == 1, "R5", "frame_len", int'(frame_len), 1);
        rx_line = 1'b1;
        repeat (5) step();

        // R6: gap captured at open; later changes ignored
        gap_len = 16'd5;
        put_byte(8'h33, 1, 0, "R6");
        arm_cyc = cyc;
        gap_len = 16'd40;
        wait_done(lat);
        chk(lat == 6, "R6", "gap captured at open", lat, 6);
        repeat (3) step();

        // R6: zero gap acts as one
        gap_len = 16'd0;
        put_byte(8'h44, 1, 0, "R6");
        arm_cyc = cyc;
        wait_done(lat);
        chk(lat == 2, "R6", "zero gap latency", lat, 2);
        repeat (3) step();

        // R9: byte in the timeout cycle is dropped and does not reopen
        gap_len = 16'd4;
        put_byte(8'h55, 1, 0, "R9");
        arm_cyc = cyc;
        repeat (4) step();   // now between edges arm+4 and arm+5: timeout due
        put_byte(8'h66, 0, 0, "R9");
        chk(frame_done == 1, "R9", "done after due cycle", int'(frame_done), 1);
        chk(frame_len == 1, "R9", "dropped byte not counted", int'(frame_len), 1);
        repeat (20) step();
        chk(frame_done == 0, "R9", "no new frame opened", int'(frame_done), 0);

        // R10: line changes while idle cause nothing
        lat = 0;
        for (int t = 0; t < 30; t++) begin
            if (t < 6) rx_line = ~rx_line;
            step();
            if (frame_done) lat++;
        end
        chk(lat == 0, "R10", "done count while idle", lat, 0);

        // R1: reset mid-frame clears everything
        gap_len = 16'd6;
        put_byte(8'h77, 1, 0, "R1");
        put_byte(8'h78, 1, 1, "R1");
        rst_n = 1'b0;
        step();
        chk(frame_done == 0 && frame_len == 0 && frame_ovf == 0, "R1",
            "mid-frame reset len", int'(frame_len), 0);
        rst_n = 1'b1;
        lat = 0;
        for (int t = 0; t < 20; t++) begin
            step();
            if (frame_done) lat++;
        end
        chk(lat == 0, "R1", "no done after reset", lat, 0);
        put_byte(8'h79, 1, 0, "R11");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule